// File: doc/BRIEF.md
# Reconfigurable Sliding-Window CFAR Detector

This block decides, sample by sample, whether a range cell holds a target. It takes a stream of unsigned magnitude samples. Each accepted sample shifts a fixed-length window by one place. Run-time settings pick the layout inside that window. The newest samples form the leading reference half. Behind them come guard cells, then the cell under test, then more guard cells. The oldest samples form the lagging reference half.

Each reference half is summed and divided by its length to give one average per side. A selectable rule reduces the two averages to a noise estimate Z: their mean, the larger one, or the smaller one. Z is multiplied by an unsigned fixed-point scale factor. The cell under test is declared a target when it is strictly above that threshold. The result is a one-bit flag with a valid strobe.

The rule, the half lengths and the scale factor can be changed while samples are streaming. A change restarts the fill count, so no result is flagged valid until the newly sized window has been filled with fresh samples.

Top module: `cfar_detector`

## Requirements
- R1: While `rst` is high, and in the cycle after it drops, `out_valid` and `out_det` are 0. Reset sets the active configuration to all zeros: rule 0, size code 0, guard 0, scale 0.
- R2: The window advances by exactly one sample for each cycle in which `in_valid` is high. Cycles with `in_valid` low leave the window unchanged and produce `out_valid` = 0.
- R3: The half length is n = 2^`cfg_nlog`, and m is the guard count per side. Counting position 0 as the newest sample: the leading half is positions 0..n-1, the cell under test is position n+m, and the lagging half is positions n+2m+1..2n+2m. Guard cells never enter Z.
- R4: Each half average is floor(sum/n). Rule code 0 gives Z = floor((lag + lead)/2).
- R5: Rule code 1 gives Z = max(lag, lead) and code 2 gives Z = min(lag, lead). Code 3 behaves as code 0 and counts as the same configuration as code 0.
- R6: `cfg_alpha` is unsigned, with 4 integer bits and 8 fractional bits. `out_det` is 1 exactly when cut·256 > alpha·Z, compared exactly with no rounding. Equality gives 0.
- R7: `out_valid` pulses one cycle after the edge that accepted a sample. It pulses only if at least 2n+2m+1 samples have been accepted since the last configuration change. When `out_valid` is 0, `out_det` is 0.
- R8: The configuration inputs are sampled every cycle. Any change in the sanitized rule, size, guard or scale restarts the fill count. The sample accepted on that same edge counts as the first new sample.
- R9: A guard input above the guard maximum (4 by default) is treated as the maximum. A size code above the size maximum is treated as the maximum. A change that clamps to the active value is not a change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | New sample present this cycle |
| in_data | input | DW | Unsigned magnitude sample |
| cfg_mode | input | 2 | Rule: 0 mean, 1 larger, 2 smaller, 3 as 0 |
| cfg_nlog | input | NLW | log2 of the reference half length |
| cfg_guard | input | MW | Guard cells per side |
| cfg_alpha | input | AW | Scale factor, 4.8 unsigned fixed point |
| out_valid | output | 1 | Decision strobe |
| out_det | output | 1 | Target flag for the cell under test |

## Verification
Every accepted sample is checked against a model of the window. The test table uses a pseudo-noise floor with isolated spikes, a clutter step, an alternating low/high floor, and full-scale values with maximum scale. The clutter step is what separates the larger and smaller rules from the mean rule. The alternating floor shows whether the averages are taken over the intended taps. The full-scale run exposes any overflow in the product.

Directed runs then cover three more points. They place the cell under test exactly on the threshold, both at integer and at fractional scale, to pin down the strict comparison. They put large values in the guard cells. They also feed configuration writes that change only the scale, only the rule encoding, or an out-of-range guard value, which separates a true restart from a no-op.

// File: rtl/cfar_pkg.sv
package cfar_pkg;

    typedef enum logic [1:0] {
        MODE_CA  = 2'd0,
        MODE_GO  = 2'd1,
        MODE_SO  = 2'd2,
        MODE_ALT = 2'd3
    } cfar_mode_e;

    // Code 3 is folded onto the mean rule so it compares equal to code 0.
    function automatic cfar_mode_e mode_sanitize(input logic [1:0] code);
        return (code == 2'd3) ? MODE_CA : cfar_mode_e'(code);
    endfunction

    // Number of samples a window of 2^nlog reference cells per side needs.
    function automatic int unsigned window_need(input int unsigned nlog,
                                                input int unsigned guard);
        return (2 << nlog) + 2 * guard + 1;
    endfunction

endpackage

// File: rtl/cfar_ctrl.sv
module cfar_ctrl
    import cfar_pkg::*;
#(
    parameter  int NLOG_MAX = 3,
    parameter  int MMAX     = 4,
    parameter  int AW       = 12,
    localparam int NLW      = $clog2(NLOG_MAX + 1),
    localparam int MW       = $clog2(MMAX + 1),
    localparam int L        = 2 * (1 << NLOG_MAX) + 2 * MMAX + 1,
    localparam int FW       = $clog2(L + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       cfg_mode,
    input  logic [NLW-1:0]   cfg_nlog,
    input  logic [MW-1:0]    cfg_guard,
    input  logic [AW-1:0]    cfg_alpha,
    output cfar_mode_e       act_mode,
    output logic [NLW-1:0]   act_nlog,
    output logic [MW-1:0]    act_guard,
    output logic [AW-1:0]    act_alpha,
    output logic             win_full,
    output logic             restart
);

    cfar_mode_e     mode_c;
    logic [NLW-1:0] nlog_c;
    logic [MW-1:0]  guard_c;
    logic [FW-1:0]  need;
    logic [FW-1:0]  fill_q;

    always_comb begin
        mode_c  = mode_sanitize(cfg_mode);
        nlog_c  = (cfg_nlog > NLW'(NLOG_MAX)) ? NLW'(NLOG_MAX) : cfg_nlog;
        guard_c = (cfg_guard > MW'(MMAX)) ? MW'(MMAX) : cfg_guard;
        restart = (mode_c != act_mode) || (nlog_c != act_nlog) ||
                  (guard_c != act_guard) || (cfg_alpha != act_alpha);
        need    = FW'(window_need(int'(act_nlog), int'(act_guard)));
        win_full = (fill_q >= need);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_mode  <= MODE_CA;
            act_nlog  <= '0;
            act_guard <= '0;
            act_alpha <= '0;
            fill_q    <= '0;
        end else if (restart) begin
            act_mode  <= mode_c;
            act_nlog  <= nlog_c;
            act_guard <= guard_c;
            act_alpha <= cfg_alpha;
            fill_q    <= in_valid ? FW'(1) : '0;
        end else if (in_valid && (fill_q < need)) begin
            fill_q <= fill_q + FW'(1);
        end
    end

    AST_FILL_RESTART: assert property (@(posedge clk) disable iff (rst)
        restart |=> (fill_q <= FW'(1)));                            // R8
    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
        fill_q <= need);                                            // R7
    AST_GUARD_CLAMP: assert property (@(posedge clk) disable iff (rst)
        act_guard <= MW'(MMAX));                                    // R9

endmodule

// File: rtl/cfar_window.sv
module cfar_window #(
    parameter  int DW       = 8,
    parameter  int NLOG_MAX = 3,
    parameter  int MMAX     = 4,
    localparam int NMAX     = 1 << NLOG_MAX,
    localparam int NLW      = $clog2(NLOG_MAX + 1),
    localparam int MW       = $clog2(MMAX + 1),
    localparam int L        = 2 * NMAX + 2 * MMAX + 1,
    localparam int IW       = $clog2(L),
    localparam int SW       = DW + NLOG_MAX
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [DW-1:0]  in_data,
    input  logic [NLW-1:0] act_nlog,
    input  logic [MW-1:0]  act_guard,
    output logic [SW-1:0]  sum_lead,
    output logic [SW-1:0]  sum_lag,
    output logic [DW-1:0]  cut
);

    logic [DW-1:0]     win_q [L];
    logic [DW-1:0]     lead_tap [NMAX];
    logic [DW-1:0]     lag_tap  [NMAX];
    logic [NLOG_MAX:0] n_val;
    logic [IW-1:0]     lag_base;
    logic [IW-1:0]     cut_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int t = 0; t < L; t++) win_q[t] <= '0;
        end else if (in_valid) begin
            win_q[0] <= in_data;
            for (int t = 1; t < L; t++) win_q[t] <= win_q[t-1];
        end
    end

    always_comb begin
        n_val    = (NLOG_MAX+1)'(1) << act_nlog;
        cut_idx  = IW'(n_val) + IW'(act_guard);
        lag_base = IW'(n_val) + IW'({act_guard, 1'b0}) + IW'(1);
        cut      = win_q[cut_idx];
    end

    for (genvar j = 0; j < NMAX; j++) begin : g_ref
        logic [IW:0] lag_idx;
        assign lag_idx     = {1'b0, lag_base} + (IW+1)'(j);
        assign lead_tap[j] = ((NLOG_MAX+1)'(j) < n_val) ? win_q[j] : '0;
        assign lag_tap[j]  = (((NLOG_MAX+1)'(j) < n_val) && (lag_idx < (IW+1)'(L)))
                             ? win_q[lag_idx[IW-1:0]] : '0;
    end

    always_comb begin
        sum_lead = '0;
        sum_lag  = '0;
        for (int j = 0; j < NMAX; j++) begin
            sum_lead = sum_lead + SW'(lead_tap[j]);
            sum_lag  = sum_lag  + SW'(lag_tap[j]);
        end
    end

    AST_SHIFT_LOAD: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (win_q[0] == $past(in_data)));                 // R2
    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(win_q[0]) && $stable(win_q[L-1])));  // R2

endmodule

// File: rtl/cfar_decide.sv
module cfar_decide
    import cfar_pkg::*;
#(
    parameter  int DW       = 8,
    parameter  int NLOG_MAX = 3,
    parameter  int AW       = 12,
    parameter  int AFRAC    = 8,
    localparam int NLW      = $clog2(NLOG_MAX + 1),
    localparam int SW       = DW + NLOG_MAX,
    localparam int PW       = AW + DW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic           win_full,
    input  cfar_mode_e     act_mode,
    input  logic [NLW-1:0] act_nlog,
    input  logic [AW-1:0]  act_alpha,
    input  logic [SW-1:0]  sum_lead,
    input  logic [SW-1:0]  sum_lag,
    input  logic [DW-1:0]  cut,
    output logic           out_valid,
    output logic           out_det
);

    logic [DW-1:0] y_lag;
    logic [DW-1:0] y_lead;
    logic [DW-1:0] z;
    logic [PW-1:0] prod;
    logic [PW-1:0] cut_scaled;
    logic          hit;
    logic          shift_q;

    always_comb begin
        y_lag  = DW'(sum_lag >> act_nlog);
        y_lead = DW'(sum_lead >> act_nlog);
        unique case (act_mode)
            MODE_GO: z = (y_lag > y_lead) ? y_lag : y_lead;
            MODE_SO: z = (y_lag < y_lead) ? y_lag : y_lead;
            default: z = DW'(((DW+1)'(y_lag) + (DW+1)'(y_lead)) >> 1);
        endcase
        prod       = PW'(act_alpha) * PW'(z);
        cut_scaled = PW'({cut, {AFRAC{1'b0}}});
        hit        = cut_scaled > prod;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q   <= 1'b0;
            out_valid <= 1'b0;
            out_det   <= 1'b0;
        end else begin
            shift_q   <= in_valid;
            out_valid <= shift_q && win_full;
            out_det   <= shift_q && win_full && hit;
        end
    end

    AST_GO_UPPER: assert property (@(posedge clk) disable iff (rst)
        (act_mode == MODE_GO) |-> (z >= y_lag && z >= y_lead));     // R5
    AST_SO_LOWER: assert property (@(posedge clk) disable iff (rst)
        (act_mode == MODE_SO) |-> (z <= y_lag && z <= y_lead));     // R5
    AST_CA_BETWEEN: assert property (@(posedge clk) disable iff (rst)
        (act_mode == MODE_CA) |-> ((z >= y_lag || z >= y_lead) &&
                                   (z <= y_lag || z <= y_lead)));  // R4

endmodule

// File: rtl/cfar_detector.sv
module cfar_detector
    import cfar_pkg::*;
#(
    parameter  int DW       = 8,
    parameter  int NLOG_MAX = 3,
    parameter  int MMAX     = 4,
    parameter  int AW       = 12,
    parameter  int AFRAC    = 8,
    localparam int NLW      = $clog2(NLOG_MAX + 1),
    localparam int MW       = $clog2(MMAX + 1),
    localparam int SW       = DW + NLOG_MAX
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [DW-1:0]  in_data,
    input  logic [1:0]     cfg_mode,
    input  logic [NLW-1:0] cfg_nlog,
    input  logic [MW-1:0]  cfg_guard,
    input  logic [AW-1:0]  cfg_alpha,
    output logic           out_valid,
    output logic           out_det
);

    cfar_mode_e     act_mode;
    logic [NLW-1:0] act_nlog;
    logic [MW-1:0]  act_guard;
    logic [AW-1:0]  act_alpha;
    logic           win_full;
    logic           restart;
    logic [SW-1:0]  sum_lead;
    logic [SW-1:0]  sum_lag;
    logic [DW-1:0]  cut;

    cfar_ctrl #(.NLOG_MAX(NLOG_MAX), .MMAX(MMAX), .AW(AW)) ctrl_i (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .cfg_mode(cfg_mode), .cfg_nlog(cfg_nlog), .cfg_guard(cfg_guard),
        .cfg_alpha(cfg_alpha),
        .act_mode(act_mode), .act_nlog(act_nlog), .act_guard(act_guard),
        .act_alpha(act_alpha), .win_full(win_full), .restart(restart)
    );

    cfar_window #(.DW(DW), .NLOG_MAX(NLOG_MAX), .MMAX(MMAX)) window_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .act_nlog(act_nlog), .act_guard(act_guard),
        .sum_lead(sum_lead), .sum_lag(sum_lag), .cut(cut)
    );

    cfar_decide #(.DW(DW), .NLOG_MAX(NLOG_MAX), .AW(AW), .AFRAC(AFRAC)) decide_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .win_full(win_full),
        .act_mode(act_mode), .act_nlog(act_nlog), .act_alpha(act_alpha),
        .sum_lead(sum_lead), .sum_lag(sum_lag), .cut(cut),
        .out_valid(out_valid), .out_det(out_det)
    );

    AST_VALID_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 2));                          // R7
    AST_RESTART_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        restart |=> ##1 !out_valid);                                // R8
    AST_DET_GATED: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !out_det);                                   // R7

endmodule

// File: tb/cfar_detector_tb_top.sv
module cfar_detector_tb_top;

    localparam int L = 25;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic [1:0] cfg_mode = '0;
    logic [1:0] cfg_nlog = '0;
    logic [2:0] cfg_guard = '0;
    logic [11:0] cfg_alpha = '0;
    logic       out_valid;
    logic       out_det;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    int hist [L];
    int fill_b = 0;
    int b_mode = 0, b_nlog = 0, b_guard = 0, b_alpha = 0;

    always #5 clk = ~clk;

    cfar_detector dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .cfg_mode(cfg_mode), .cfg_nlog(cfg_nlog), .cfg_guard(cfg_guard),
        .cfg_alpha(cfg_alpha), .out_valid(out_valid), .out_det(out_det)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [1:0]  nlog;
        logic [2:0]  guard;
        logic [11:0] alpha;
        logic [1:0]  pat;
        logic [7:0]  count;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd0, 2'd1, 3'd1, 12'h200, 2'd0, 8'd30},
        '{2'd1, 2'd1, 3'd1, 12'h200, 2'd1, 8'd30},
        '{2'd2, 2'd1, 3'd1, 12'h200, 2'd1, 8'd30},
        '{2'd0, 2'd3, 3'd4, 12'h180, 2'd0, 8'd40},
        '{2'd1, 2'd2, 3'd2, 12'h140, 2'd2, 8'd30},
        '{2'd2, 2'd0, 3'd0, 12'h300, 2'd2, 8'd20},
        '{2'd3, 2'd2, 3'd7, 12'h100, 2'd0, 8'd40},
        '{2'd1, 2'd3, 3'd0, 12'hFFF, 2'd3, 8'd30}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int gen(input int pat, input int k);
        case (pat)
            0: return (k % 7 == 3) ? 180 : ((k * 37) % 23) + 8;
            1: return (k % 6 == 0) ? 230 : (k < 15 ? ((k * 5) % 9) + 5 : ((k * 7) % 13) + 90);
            2: return (k % 9 == 4) ? 150 : ((k % 2 == 1) ? 60 : 6);
            default: return (k % 3 == 0) ? 255 : 0;
        endcase
    endfunction

    function automatic int need_b();
        return 2 * (1 << b_nlog) + 2 * b_guard + 1;
    endfunction

    // Spec model of the decision for the bench's own sample record.
    function automatic int model_det();
        int n = 1 << b_nlog;
        int s_lead = 0, s_lag = 0, a_lead, a_lag, z;
        for (int j = 0; j < n; j++) begin
            s_lead += hist[j];
            s_lag  += hist[n + 2 * b_guard + 1 + j];
        end
        a_lead = s_lead / n;
        a_lag  = s_lag / n;
        if (b_mode == 1)      z = (a_lead > a_lag) ? a_lead : a_lag;
        else if (b_mode == 2) z = (a_lead < a_lag) ? a_lead : a_lag;
        else                  z = (a_lead + a_lag) / 2;
        return (hist[n + b_guard] * 256 > b_alpha * z) ? 1 : 0;
    endfunction

    task automatic apply_cfg(input int mode, input int nlog, input int guard, input int alpha);
        int m_c = (mode == 3) ? 0 : mode;
        int g_c = (guard > 4) ? 4 : guard;
        cfg_mode  = 2'(mode);
        cfg_nlog  = 2'(nlog);
        cfg_guard = 3'(guard);
        cfg_alpha = 12'(alpha);
        if (m_c != b_mode || nlog != b_nlog || g_c != b_guard || alpha != b_alpha)
            fill_b = 0;
        b_mode = m_c; b_nlog = nlog; b_guard = g_c; b_alpha = alpha;
    endtask

    task automatic push(input int d);
        int ev, ed;
        in_data  = 8'(d);
        in_valid = 1'b1;
        @(posedge clk);
        #1 in_valid = 1'b0;
        for (int i = L - 1; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = d;
        fill_b++;
        @(posedge clk);
        #1;
        ev = (fill_b >= need_b()) ? 1 : 0;
        ed = ev ? model_det() : 0;
        check("R7", "out_valid", int'(out_valid), ev);
        check(b_mode == 0 ? "R4" : "R5", "out_det", int'(out_det), ed);
    endtask

    initial begin
        for (int i = 0; i < L; i++) hist[i] = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "out_valid in reset", int'(out_valid), 0);
        check("R1", "out_det in reset", int'(out_det), 0);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R1", "out_valid after reset", int'(out_valid), 0);
        check("R1", "out_det after reset", int'(out_det), 0);

        // Table of configurations and stimulus patterns
        for (int v = 0; v < 8; v++) begin
            apply_cfg(int'(VECS[v].mode), int'(VECS[v].nlog),
                      int'(VECS[v].guard), int'(VECS[v].alpha));
            for (int k = 0; k < int'(VECS[v].count); k++)
                push(gen(int'(VECS[v].pat), k + v));
        end

        // R6: strict compare at integer scale
        apply_cfg(0, 0, 0, 256);
        push(40); push(50); push(60);
        check("R6", "equal to threshold", int'(out_det), 0);
        push(40); push(50); push(58);
        check("R6", "one above threshold", int'(out_det), 1);
        // R6: fractional scale 1.5
        apply_cfg(0, 0, 0, 384);
        push(40); push(60); push(40);
        check("R6", "equal at 1.5", int'(out_det), 0);
        push(40); push(61); push(40);
        check("R6", "above at 1.5", int'(out_det), 1);

        // R3: guard cells excluded from Z
        apply_cfg(0, 0, 1, 256);
        push(10); push(250); push(20); push(250); push(10);
        check("R3", "guards ignored", int'(out_det), 1);
        check("R3", "valid after fill", int'(out_valid), 1);

        // R2: idle cycles give no strobe and leave the window alone
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            #1 check("R2", "idle out_valid", int'(out_valid), 0);
        end
        push(15);

        // R9: out-of-range guard clamps and is not a change
        apply_cfg(0, 0, 4, 256);
        for (int k = 0; k < 11; k++) push(gen(0, k));
        apply_cfg(0, 0, 7, 256);
        push(33);
        check("R9", "clamped guard keeps fill", int'(out_valid), 1);

        // R5: code 3 equals code 0, no restart
        apply_cfg(3, 0, 4, 256);
        push(90);
        check("R5", "code 3 same as 0", int'(out_valid), 1);

        // R8: scale-only change restarts the fill
        apply_cfg(0, 0, 4, 300);
        push(12);
        check("R8", "valid after change", int'(out_valid), 0);
        for (int k = 0; k < 10; k++) push(gen(2, k));
        check("R8", "valid after refill", int'(out_valid), 1);

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule